// File: doc/BRIEF.md
# I2C Slave Receive Engine

This block is the receive side of an I2C slave. It watches the bus clock and data lines, which it brings into the system clock domain itself. It finds START and STOP conditions and shifts in an address byte followed by data bytes. When the upper seven bits of the address byte equal a programmable own address and the direction bit asks for a write, it acknowledges by pulling SDA low during the ninth clock pulse. After that it accepts data bytes, eight clock pulses each.

Each accepted byte is handled the same way. If the receive buffer is free and no overrun is pending, the byte is stored, the full flag is set and the byte is acknowledged. Otherwise the byte is dropped and no acknowledge is given. In every case the interrupt flag is raised at the end of the ninth pulse. The three flags are cleared by different agents. The full flag clears when the CPU reads the buffer. The overrun and interrupt flags clear only through a write-one-to-clear on the status register. An option selects the SCL edge on which data is sampled. A second option holds SCL low after each stored byte until the CPU reads it.

The CPU sees four registers at a 2-bit address:

| Address | Register |
|---|---|
| 0 | receive buffer |
| 1 | status |
| 2 | control |
| 3 | own address, in bits [7:1] |

Reads return the register selected by the address and have no side effect unless the read strobe is high.

Top module: `i2c_rx_slave`

## Requirements
- R1: After reset the buffer, status and control registers and the own-address register read 0, both drive enables are low and irq_o is low.
- R2: An address byte with bit 0 = 0 whose bits [7:1] equal bits [7:1] of register 3, arriving with full (status bit 0) and overrun (status bit 1) clear, is acknowledged (sda_oe_o high through the ninth clock pulse), is stored in register 0, sets full, and clears the direction flag (status bit 3).
- R3: An address byte whose bits [7:1] differ from the own address, or that matches with bit 0 = 1, is not acknowledged, raises no interrupt and leaves the buffer unchanged. The bytes that follow it are ignored until the next START. A match with bit 0 = 1 sets the direction flag.
- R4: The interrupt flag (status bit 2, also driven on irq_o) is set at the end of the ninth clock pulse of every accepted byte (a matching write address, or a data byte), whether or not the byte was acknowledged.
- R5: When full is set as a byte completes, the byte is not acknowledged, the buffer keeps its old content and overrun is set.
- R6: When overrun is set and full is clear as a byte completes, the byte is discarded without an acknowledge, the buffer is unchanged and full stays clear.
- R7: A read of register 0 with cpu_rd_i high clears full. Overrun and interrupt clear only by writing 1 to status bit 1 and bit 2 respectively; writing 0 to those bits leaves them set.
- R8: After an acknowledged address, each further eight clock pulses form one data byte, received MSB first, and follow the same store, acknowledge and interrupt rules.
- R9: Control bit 1 = 0 samples SDA on the SCL rising edge and = 1 samples it on the SCL falling edge. Both give the same bytes on a well-formed bus.
- R10: With control bit 2 set, SCL is held low (scl_oe_o high) from the end of the ninth pulse of a stored byte until register 0 is read.
- R11: A STOP returns the engine to idle: clock pulses without a START are ignored, and a following START begins a new address byte.
- R12: With control bit 0 (enable) clear, the bus is ignored and neither line is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous reset, active low |
| scl_i | input | 1 | SCL line level, asynchronous |
| sda_i | input | 1 | SDA line level, asynchronous |
| scl_oe_o | output | 1 | pull SCL low (clock hold) |
| sda_oe_o | output | 1 | pull SDA low (acknowledge) |
| cpu_addr_i | input | 2 | register select |
| cpu_rd_i | input | 1 | read strobe (side effect on register 0) |
| cpu_wr_i | input | 1 | write strobe |
| cpu_wdata_i | input | DATA_W | write data |
| cpu_rdata_o | output | DATA_W | read data of the selected register |
| irq_o | output | 1 | interrupt request |

## Verification
A bus edge passes through two synchroniser flops and one edge-detect comparison before the engine state changes. The acknowledge drive, the full flag and the stored byte therefore appear three clock cycles after the eighth SCL fall. The interrupt flag and the clock hold appear three cycles after the ninth fall. The bench model of the bus master holds every bus phase for six cycles and samples the acknowledge in the middle of the ninth high phase. It reads flags at a falling clock edge a full phase after the SCL edge that caused them. Register effects of a CPU strobe are visible at the falling edge that follows the strobe's rising edge, and the bench checks them there.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;

   typedef enum logic [2:0] {
      S_IDLE = 3'd0,
      S_ADDR = 3'd1,
      S_DATA = 3'd2,
      S_ACK  = 3'd3,
      S_SKIP = 3'd4
   } rx_state_t;

   localparam logic [1:0] REG_RXBUF = 2'd0;
   localparam logic [1:0] REG_STAT  = 2'd1;
   localparam logic [1:0] REG_CTRL  = 2'd2;
   localparam logic [1:0] REG_OWN   = 2'd3;

   localparam int STAT_FULL = 0;
   localparam int STAT_OVF  = 1;
   localparam int STAT_IRQ  = 2;
   localparam int STAT_DIR  = 3;

   localparam int CTRL_EN   = 0;
   localparam int CTRL_FALL = 1;
   localparam int CTRL_HOLD = 2;

endpackage

// File: rtl/i2c_rx_sync.sv
module i2c_rx_sync #(
   parameter int STAGES   = 2,
   parameter bit IDLE_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_rx_sync: STAGES must be at least 2");
   end

   for (genvar k = 0; k < STAGES; k++) begin : g_st
      logic nxt;
      logic ff_q;
      if (k == 0) begin : g_in
         assign nxt = d_i;
      end else begin : g_chain
         assign nxt = g_st[k-1].ff_q;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ff_q <= IDLE_VAL;
         else        ff_q <= nxt;
      end
   end

   assign q_o = g_st[STAGES-1].ff_q;

endmodule

// File: rtl/i2c_rx_engine.sv
module i2c_rx_engine
   import i2c_rx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              fall_latch_i,
   input  logic              hold_en_i,
   input  logic [DATA_W-2:0] own_addr_i,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic              full_i,
   input  logic              ovf_i,
   input  logic              rd_clr_i,
   output logic              store_o,
   output logic [DATA_W-1:0] byte_o,
   output logic              ovf_set_o,
   output logic              irq_set_o,
   output logic              dir_set_o,
   output logic              dir_val_o,
   output logic              sda_oe_o,
   output logic              scl_oe_o
);

   localparam int              CNT_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

   logic              scl_q, sda_q;
   logic              scl_rise, scl_fall, start_c, stop_c;
   rx_state_t         st_q;
   logic [DATA_W-1:0] sh_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              pulse_q, ack_q, acc_q, go_q, hold_q;
   logic [DATA_W-1:0] byte_c;
   logic              end_c, shifting_c, done_c, hit_c, acc_c, take_c, go_c;

   // bus condition detection on the synchronised lines
   assign scl_rise = scl_i & ~scl_q;
   assign scl_fall = ~scl_i & scl_q;
   assign start_c  = scl_i & scl_q & sda_q & ~sda_i;
   assign stop_c   = scl_i & scl_q & ~sda_q & sda_i;

   // a pulse ends on a fall that follows a rise seen in this bit
   assign end_c      = scl_fall & pulse_q;
   assign shifting_c = (st_q == S_ADDR) || (st_q == S_DATA);
   assign byte_c     = fall_latch_i ? {sh_q[DATA_W-2:0], sda_i} : sh_q;
   assign done_c     = en_i & shifting_c & end_c & (cnt_q == LAST);
   assign hit_c      = (byte_c[DATA_W-1:1] == own_addr_i);
   assign acc_c      = (st_q == S_DATA) | (hit_c & ~byte_c[0]);
   assign take_c     = acc_c & ~full_i & ~ovf_i;
   assign go_c       = (st_q == S_DATA) | take_c;

   assign store_o   = done_c & take_c;
   assign byte_o    = byte_c;
   assign ovf_set_o = done_c & acc_c & full_i;
   assign dir_set_o = done_c & (st_q == S_ADDR) & hit_c;
   assign dir_val_o = byte_c[0];
   assign irq_set_o = en_i & (st_q == S_ACK) & end_c & acc_q;
   assign sda_oe_o  = (st_q == S_ACK) & ack_q;
   assign scl_oe_o  = hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q   <= 1'b1;
         sda_q   <= 1'b1;
         st_q    <= S_IDLE;
         sh_q    <= '0;
         cnt_q   <= '0;
         pulse_q <= 1'b0;
         ack_q   <= 1'b0;
         acc_q   <= 1'b0;
         go_q    <= 1'b0;
      end else begin
         scl_q <= scl_i;
         sda_q <= sda_i;
         if (!en_i) begin
            st_q    <= S_IDLE;
            pulse_q <= 1'b0;
            ack_q   <= 1'b0;
         end else if (start_c) begin
            st_q    <= S_ADDR;
            cnt_q   <= '0;
            pulse_q <= 1'b0;
            ack_q   <= 1'b0;
         end else if (stop_c) begin
            st_q  <= S_IDLE;
            ack_q <= 1'b0;
         end else begin
            if (scl_rise)      pulse_q <= 1'b1;
            else if (scl_fall) pulse_q <= 1'b0;
            case (st_q)
               S_ADDR, S_DATA: begin
                  if (scl_rise && !fall_latch_i) sh_q <= {sh_q[DATA_W-2:0], sda_i};
                  if (end_c) begin
                     if (fall_latch_i) sh_q <= byte_c;
                     if (cnt_q == LAST) begin
                        cnt_q <= '0;
                        st_q  <= S_ACK;
                        ack_q <= take_c;
                        acc_q <= acc_c;
                        go_q  <= go_c;
                     end else begin
                        cnt_q <= cnt_q + 1'b1;
                     end
                  end
               end
               S_ACK: begin
                  if (end_c) begin
                     ack_q <= 1'b0;
                     st_q  <= go_q ? S_DATA : S_SKIP;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // optional clock hold after a stored byte, released by the buffer read
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              hold_q <= 1'b0;
      else if (!en_i || rd_clr_i || stop_c)    hold_q <= 1'b0;
      else if ((st_q == S_ACK) && end_c && ack_q && hold_en_i && full_i)
                                               hold_q <= 1'b1;
   end

   // R2: an acknowledge only starts when the buffer was free and no overrun pending
   a_r2_ack_needs_room: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe_o) |-> (!$past(full_i) && !$past(ovf_i)));

endmodule

// File: rtl/i2c_rx_regs.sv
module i2c_rx_regs
   import i2c_rx_pkg::*;
#(
   parameter int              DATA_W  = 8,
   parameter logic [DATA_W-2:0] OWN_RST = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cpu_addr_i,
   input  logic              cpu_rd_i,
   input  logic              cpu_wr_i,
   input  logic [DATA_W-1:0] cpu_wdata_i,
   output logic [DATA_W-1:0] cpu_rdata_o,
   input  logic              store_i,
   input  logic [DATA_W-1:0] byte_i,
   input  logic              ovf_set_i,
   input  logic              irq_set_i,
   input  logic              dir_set_i,
   input  logic              dir_val_i,
   output logic              en_o,
   output logic              fall_latch_o,
   output logic              hold_en_o,
   output logic [DATA_W-2:0] own_addr_o,
   output logic              full_o,
   output logic              ovf_o,
   output logic              irq_o,
   output logic              rd_clr_o
);

   logic [DATA_W-1:0] buf_q;
   logic [DATA_W-2:0] own_q;
   logic              full_q, ovf_q, irq_q, dir_q;
   logic              en_q, fall_q, hold_q;
   logic              wr_stat, wr_ctrl, wr_own, clr_ovf, clr_irq;

   assign rd_clr_o = cpu_rd_i & (cpu_addr_i == REG_RXBUF);
   assign wr_stat  = cpu_wr_i & (cpu_addr_i == REG_STAT);
   assign wr_ctrl  = cpu_wr_i & (cpu_addr_i == REG_CTRL);
   assign wr_own   = cpu_wr_i & (cpu_addr_i == REG_OWN);
   assign clr_ovf  = wr_stat & cpu_wdata_i[STAT_OVF];
   assign clr_irq  = wr_stat & cpu_wdata_i[STAT_IRQ];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q  <= '0;
         full_q <= 1'b0;
         ovf_q  <= 1'b0;
         irq_q  <= 1'b0;
         dir_q  <= 1'b0;
      end else begin
         if (store_i) buf_q <= byte_i;
         if (store_i)       full_q <= 1'b1;
         else if (rd_clr_o) full_q <= 1'b0;
         if (ovf_set_i)     ovf_q <= 1'b1;
         else if (clr_ovf)  ovf_q <= 1'b0;
         if (irq_set_i)     irq_q <= 1'b1;
         else if (clr_irq)  irq_q <= 1'b0;
         if (dir_set_i)     dir_q <= dir_val_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         fall_q <= 1'b0;
         hold_q <= 1'b0;
         own_q  <= OWN_RST;
      end else begin
         if (wr_ctrl) begin
            en_q   <= cpu_wdata_i[CTRL_EN];
            fall_q <= cpu_wdata_i[CTRL_FALL];
            hold_q <= cpu_wdata_i[CTRL_HOLD];
         end
         if (wr_own) own_q <= cpu_wdata_i[DATA_W-1:1];
      end
   end

   always_comb begin
      cpu_rdata_o = '0;
      case (cpu_addr_i)
         REG_RXBUF: cpu_rdata_o = buf_q;
         REG_STAT: begin
            cpu_rdata_o[STAT_FULL] = full_q;
            cpu_rdata_o[STAT_OVF]  = ovf_q;
            cpu_rdata_o[STAT_IRQ]  = irq_q;
            cpu_rdata_o[STAT_DIR]  = dir_q;
         end
         REG_CTRL: begin
            cpu_rdata_o[CTRL_EN]   = en_q;
            cpu_rdata_o[CTRL_FALL] = fall_q;
            cpu_rdata_o[CTRL_HOLD] = hold_q;
         end
         default: cpu_rdata_o = {own_q, 1'b0};
      endcase
   end

   assign en_o         = en_q;
   assign fall_latch_o = fall_q;
   assign hold_en_o    = hold_q;
   assign own_addr_o   = own_q;
   assign full_o       = full_q;
   assign ovf_o        = ovf_q;
   assign irq_o        = irq_q;

   // R5: an occupied buffer is never overwritten until it is read
   a_r5_buffer_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (full_q && !rd_clr_o) |=> $stable(buf_q));

   // R7: overrun only clears through a write of one to its status bit
   a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !clr_ovf) |=> ovf_q);

   // R4: the interrupt flag stays until software clears it
   a_r4_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && !clr_irq) |=> irq_q);

endmodule

// File: rtl/i2c_rx_slave.sv
module i2c_rx_slave
   import i2c_rx_pkg::*;
#(
   parameter int                DATA_W      = 8,
   parameter int                SYNC_STAGES = 2,
   parameter logic [DATA_W-2:0] OWN_RST     = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              scl_oe_o,
   output logic              sda_oe_o,
   input  logic [1:0]        cpu_addr_i,
   input  logic              cpu_rd_i,
   input  logic              cpu_wr_i,
   input  logic [DATA_W-1:0] cpu_wdata_i,
   output logic [DATA_W-1:0] cpu_rdata_o,
   output logic              irq_o
);

   if (DATA_W < 4) begin : g_bad_width
      $error("i2c_rx_slave: DATA_W must be at least 4 to hold the status bits");
   end

   logic              scl_s, sda_s;
   logic              en, fall_latch, hold_en, full, ovf, rd_clr;
   logic [DATA_W-2:0] own_addr;
   logic              store, ovf_set, irq_set, dir_set, dir_val;
   logic [DATA_W-1:0] rx_byte;

   i2c_rx_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) i_sync_scl (
      .clk(clk), .rst_n(rst_n), .d_i(scl_i), .q_o(scl_s));

   i2c_rx_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) i_sync_sda (
      .clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_s));

   i2c_rx_engine #(.DATA_W(DATA_W)) i_engine (
      .clk(clk), .rst_n(rst_n),
      .en_i(en), .fall_latch_i(fall_latch), .hold_en_i(hold_en),
      .own_addr_i(own_addr), .scl_i(scl_s), .sda_i(sda_s),
      .full_i(full), .ovf_i(ovf), .rd_clr_i(rd_clr),
      .store_o(store), .byte_o(rx_byte), .ovf_set_o(ovf_set),
      .irq_set_o(irq_set), .dir_set_o(dir_set), .dir_val_o(dir_val),
      .sda_oe_o(sda_oe_o), .scl_oe_o(scl_oe_o));

   i2c_rx_regs #(.DATA_W(DATA_W), .OWN_RST(OWN_RST)) i_regs (
      .clk(clk), .rst_n(rst_n),
      .cpu_addr_i(cpu_addr_i), .cpu_rd_i(cpu_rd_i), .cpu_wr_i(cpu_wr_i),
      .cpu_wdata_i(cpu_wdata_i), .cpu_rdata_o(cpu_rdata_o),
      .store_i(store), .byte_i(rx_byte), .ovf_set_i(ovf_set),
      .irq_set_i(irq_set), .dir_set_i(dir_set), .dir_val_i(dir_val),
      .en_o(en), .fall_latch_o(fall_latch), .hold_en_o(hold_en),
      .own_addr_o(own_addr), .full_o(full), .ovf_o(ovf), .irq_o(irq_o),
      .rd_clr_o(rd_clr));

   // R10: the clock is only held while a stored byte waits to be read
   a_r10_hold_with_full: assert property (@(posedge clk) disable iff (!rst_n)
      scl_oe_o |-> full);

   // R12: a disabled engine releases both lines on the next cycle
   a_r12_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!sda_oe_o && !scl_oe_o));

endmodule

// File: tb/test_i2c_rx_slave.sv
module test_i2c_rx_slave;
   localparam int W = 8;
   localparam int Q = 6;
   localparam logic [7:0] OWN_W = 8'hB4;   // own address 0x5A, write

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic scl_m = 1'b1, sda_m = 1'b1;
   logic scl_oe, sda_oe, scl_l, sda_l, irq;
   logic [1:0]   c_addr = '0;
   logic         c_rd = 1'b0, c_wr = 1'b0;
   logic [W-1:0] c_wdata = '0;
   logic [W-1:0] c_rdata;

   assign scl_l = scl_m & ~scl_oe;
   assign sda_l = sda_m & ~sda_oe;

   i2c_rx_slave i_i2c_rx_slave (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_l), .sda_i(sda_l),
      .scl_oe_o(scl_oe), .sda_oe_o(sda_oe),
      .cpu_addr_i(c_addr), .cpu_rd_i(c_rd), .cpu_wr_i(c_wr),
      .cpu_wdata_i(c_wdata), .cpu_rdata_o(c_rdata), .irq_o(irq));

   int  total = 0;
   int  bad = 0;
   bit  done = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wq(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wq(Q);
      scl_m = 1'b1; wq(Q);
      sda_m = 1'b0; wq(Q);
      scl_m = 1'b0; wq(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wq(Q);
      scl_m = 1'b1; wq(Q);
      sda_m = 1'b1; wq(Q);
   endtask

   task automatic send_bit(input logic b);
      sda_m = b; wq(Q);
      while (scl_oe) @(negedge clk);
      scl_m = 1'b1; wq(Q);
      scl_m = 1'b0; wq(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ackd);
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
      sda_m = 1'b1; wq(Q);
      scl_m = 1'b1; wq(Q);
      ackd = ~sda_l;
      scl_m = 1'b0; wq(Q);
   endtask

   task automatic cpu_write(input logic [1:0] a, input logic [W-1:0] d);
      @(negedge clk);
      c_addr = a; c_wdata = d; c_wr = 1'b1;
      @(negedge clk);
      c_wr = 1'b0;
   endtask

   task automatic cpu_read(input logic [1:0] a, output logic [W-1:0] d);
      @(negedge clk);
      c_addr = a; c_rd = 1'b1;
      #1 d = c_rdata;
      @(negedge clk);
      c_rd = 1'b0;
   endtask

   task automatic peek(input logic [1:0] a, output logic [W-1:0] d);
      @(negedge clk);
      c_addr = a;
      #1 d = c_rdata;
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      repeat (180000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired before the sequence ended");
         summary();
         $finish;
      end
   end

   initial begin
      logic [W-1:0] d;
      logic ackd;

      wq(3);
      // R1: reset state
      for (int r = 0; r < 4; r++) begin
         peek(r[1:0], d);
         chk("R1 register after reset", d, 0);
      end
      chk("R1 sda_oe after reset", sda_oe, 0);
      chk("R1 scl_oe after reset", scl_oe, 0);
      chk("R1 irq after reset", irq, 0);
      rst_n = 1'b1;
      wq(2);

      cpu_write(2'd3, OWN_W);
      peek(2'd3, d);
      chk("R2 own address readback", d, OWN_W);

      // R12: disabled engine ignores a matching address
      bus_start();
      send_byte(OWN_W, ackd);
      chk("R12 no ack while disabled", ackd, 0);
      peek(2'd1, d);
      chk("R12 status while disabled", d, 0);
      bus_stop();

      // R2: matching write address is acknowledged and stored
      cpu_write(2'd2, 8'h01);
      bus_start();
      send_byte(OWN_W, ackd);
      chk("R2 address ack", ackd, 1);
      peek(2'd1, d);
      chk("R2/R4 status full+irq, dir clear", d, 8'h05);
      chk("R4 irq pin", irq, 1);
      cpu_read(2'd0, d);
      chk("R2 stored address byte", d, OWN_W);
      peek(2'd1, d);
      chk("R7 full cleared by buffer read", d, 8'h04);
      cpu_write(2'd1, 8'h04);
      peek(2'd1, d);
      chk("R7 irq cleared by write one", d, 0);

      // R8: sweep every data byte value, rising-edge sampling
      for (int v = 0; v < 256; v++) begin
         send_byte(v[7:0], ackd);
         chk("R8 data ack", ackd, 1);
         cpu_read(2'd0, d);
         chk("R8 data byte", d, v);
      end
      cpu_write(2'd1, 8'h04);

      // R5: second byte while full
      send_byte(8'h11, ackd);
      chk("R5 first byte ack", ackd, 1);
      send_byte(8'h22, ackd);
      chk("R5 no ack when full", ackd, 0);
      peek(2'd1, d);
      chk("R5 status full+ovf+irq", d, 8'h07);
      peek(2'd0, d);
      chk("R5 buffer kept", d, 8'h11);
      cpu_write(2'd1, 8'h00);
      peek(2'd1, d);
      chk("R7 write zero leaves flags", d, 8'h07);
      cpu_write(2'd1, 8'h04);
      cpu_read(2'd0, d);
      chk("R5 read old byte", d, 8'h11);
      peek(2'd1, d);
      chk("R7 ovf survives buffer read", d, 8'h02);

      // R6: overrun pending, buffer free
      send_byte(8'h33, ackd);
      chk("R6 no ack while ovf", ackd, 0);
      peek(2'd1, d);
      chk("R6/R4 status ovf+irq, full clear", d, 8'h06);
      peek(2'd0, d);
      chk("R6 buffer unchanged", d, 8'h11);
      cpu_write(2'd1, 8'h06);
      peek(2'd1, d);
      chk("R7 ovf and irq cleared", d, 0);
      send_byte(8'h44, ackd);
      chk("R6 ack after ovf clear", ackd, 1);
      cpu_read(2'd0, d);
      chk("R6 byte after ovf clear", d, 8'h44);
      cpu_write(2'd1, 8'h04);

      // R3: mismatched address and following byte
      bus_start();
      send_byte(8'hB6, ackd);
      chk("R3 no ack on mismatch", ackd, 0);
      send_byte(8'hB4, ackd);
      chk("R3 byte after mismatch ignored", ackd, 0);
      peek(2'd1, d);
      chk("R3 no irq on mismatch", d, 0);
      peek(2'd0, d);
      chk("R3 buffer unchanged", d, 8'h44);
      // R3: matching address with read direction
      bus_start();
      send_byte(8'hB5, ackd);
      chk("R3 no ack on read address", ackd, 0);
      peek(2'd1, d);
      chk("R3 dir set, no irq", d, 8'h08);
      bus_start();
      send_byte(OWN_W, ackd);
      chk("R2 ack after repeated start", ackd, 1);
      peek(2'd1, d);
      chk("R2 dir cleared by write address", d, 8'h05);
      cpu_read(2'd0, d);
      cpu_write(2'd1, 8'h04);

      // R11: after STOP, clocking without START is ignored
      bus_stop();
      scl_m = 1'b0; wq(Q);
      send_byte(OWN_W, ackd);
      chk("R11 no ack without start", ackd, 0);
      peek(2'd1, d);
      chk("R11 status untouched", d, 0);
      bus_start();
      send_byte(OWN_W, ackd);
      chk("R11 start re-addresses", ackd, 1);
      cpu_read(2'd0, d);
      cpu_write(2'd1, 8'h04);
      bus_stop();

      // R9: falling-edge sampling
      cpu_write(2'd2, 8'h03);
      bus_start();
      send_byte(OWN_W, ackd);
      chk("R9 address ack falling mode", ackd, 1);
      cpu_read(2'd0, d);
      chk("R9 address byte falling mode", d, OWN_W);
      for (int v = 0; v < 64; v++) begin
         send_byte(8'(v * 4 + 3), ackd);
         chk("R9 data ack falling mode", ackd, 1);
         cpu_read(2'd0, d);
         chk("R9 data byte falling mode", d, (v * 4 + 3) & 8'hFF);
      end
      cpu_write(2'd1, 8'h04);
      bus_stop();

      // R10: clock hold until buffer read
      cpu_write(2'd2, 8'h05);
      bus_start();
      send_byte(OWN_W, ackd);
      chk("R10 address ack with hold", ackd, 1);
      chk("R10 scl held", scl_oe, 1);
      wq(20);
      chk("R10 scl line low while held", scl_l, 0);
      cpu_read(2'd0, d);
      chk("R10 byte under hold", d, OWN_W);
      chk("R10 scl released by read", scl_oe, 0);
      send_byte(8'h5C, ackd);
      chk("R10 data ack with hold", ackd, 1);
      chk("R10 scl held again", scl_oe, 1);
      cpu_read(2'd0, d);
      chk("R10 data under hold", d, 8'h5C);
      chk("R10 released again", scl_oe, 0);
      bus_stop();

      done = 1'b1;
      summary();
      $finish;
   end

endmodule